// File: doc/BRIEF.md
# Byte-Serial CRC-32 Remainder Engine

This block computes a 32-bit cyclic redundancy check over a byte stream. It takes one byte per clock, most significant bit first, and uses the generator 0x04C11DB7 in non-reflected form. It works on the augmented message: each accepted byte enters the low end of a 32-bit remainder register. The byte that leaves the top of the register selects one of 256 precomputed 32-bit constants, and that constant is XORed into the register. The design computes the constants itself while it is elaborated.

A transfer begins with a start pulse, which clears the remainder. Bytes follow with a valid qualifier. The final byte is flagged with last. The engine then feeds four zero bytes through the register on its own, and it raises done for one cycle when the finished remainder is on the output.

Top module: `crc32_byte_top`

## Requirements
- R1: While reset is held and after it is released, `crc_out` is 0x00000000 and `done` is 0.
- R2: `start` sets `crc_out` to 0x00000000 on the next cycle from any state. If padding is under way, `start` cancels it, and no `done` follows.
- R3: When no byte is accepted and no padding is in progress (`in_valid` low, `start` low), `crc_out` keeps its value.
- R4: Each accepted byte B changes the remainder C to {C[23:0], B} XOR T[C[31:24]]. T[i] is i·x^32 mod G, where G = x^32 + 0x04C11DB7 (bit 31 of C is the highest power).
- R5: After the byte with `in_last` is accepted, the next four cycles each apply R4 with B = 0x00 and need no input. `in_valid` and `in_byte` are ignored during those four cycles.
- R6: `done` is high for exactly one cycle, five cycles after the cycle in which the last byte is presented. In that cycle `crc_out` holds the final remainder.
- R7: The final remainder equals the bit-serial remainder of the message followed by 32 zero bits, taken MSB first with a zero preset. A single byte 0x01 gives 0x04C11DB7.
- R8: If `start` and `in_valid` are high in the same cycle, the start wins and that byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the remainder and aborts any padding |
| in_byte | input | 8 | Message byte, MSB first |
| in_valid | input | 1 | `in_byte` is present this cycle |
| in_last | input | 1 | Marks the final message byte (qualified by `in_valid`) |
| crc_out | output | 32 | Current remainder register |
| done | output | 1 | One-cycle pulse when the remainder is final |

## Verification
The assertions assume that `in_last` is only meaningful together with `in_valid`, and that a new message is not flagged as finished while the previous one is still padding. The stimulus opens every message with a start pulse and drives at least one byte. It flags the final byte exactly once, and it waits for each result before it starts the next message. During the padding window, bytes with valid high are sometimes driven on purpose, to show that they are ignored. In all other places, random valid-low gaps are mixed into the message.

// File: rtl/crc32_byte_pkg.sv
package crc32_byte_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PAD  = 1'b1
  } seq_state_e;

  // Remainder of (idx * x^CRC_W) modulo the generator, MSB-first form.
  function automatic logic [31:0] lut_entry(input int unsigned idx,
                                            input logic [31:0] poly);
    logic [31:0] r;
    r = 32'(idx) << 24;
    for (int b = 0; b < 8; b++) begin
      if (r[31]) r = (r << 1) ^ poly;
      else       r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/crc32_byte_lut.sv
module crc32_byte_lut #(
  parameter int          DATA_W = 8,
  parameter int          CRC_W  = 32,
  parameter logic [31:0] POLY   = 32'h04C11DB7
) (
  input  logic [DATA_W-1:0] idx,
  output logic [CRC_W-1:0]  value
);
  import crc32_byte_pkg::*;

  localparam int DEPTH = 1 << DATA_W;

  logic [CRC_W-1:0] rom [DEPTH];

  // Constants computed at elaboration, one per outgoing byte value.
  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = CRC_W'(lut_entry(g, POLY));
  end

  assign value = rom[idx];

endmodule

// File: rtl/crc32_pad_seq.sv
module crc32_pad_seq #(
  parameter int PAD_BYTES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  output logic accept,
  output logic pad_active,
  output logic done
);
  import crc32_byte_pkg::*;

  localparam int CNT_W = (PAD_BYTES > 1) ? $clog2(PAD_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAD_BYTES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  assign accept     = !start && (state_q == SEQ_IDLE) && in_valid;
  assign pad_active = !start && (state_q == SEQ_PAD);
  assign done       = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (start) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
    end else if (accept && in_last) begin
      state_d = SEQ_PAD;
      cnt_d   = '0;
    end else if (pad_active) begin
      if (cnt_q == CNT_LAST) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pad_active)); // R5
  AST_START_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done); // R2

endmodule

// File: rtl/crc32_rem_reg.sv
module crc32_rem_reg #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take_byte,
  input  logic              take_pad,
  input  logic [DATA_W-1:0] in_byte,
  input  logic [CRC_W-1:0]  lut_value,
  output logic [DATA_W-1:0] lut_idx,
  output logic [CRC_W-1:0]  rem
);
  logic [CRC_W-1:0]  rem_q, rem_d;
  logic [DATA_W-1:0] feed;
  logic              en;

  assign lut_idx = rem_q[CRC_W-1 -: DATA_W];
  assign feed    = take_byte ? in_byte : '0;
  assign en      = clear | take_byte | take_pad;

  always_comb begin
    if (clear) rem_d = '0;
    else       rem_d = {rem_q[CRC_W-DATA_W-1:0], feed} ^ lut_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rem_q <= '0;
    else if (en) rem_q <= rem_d;
  end

  assign rem = rem_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rem == '0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !take_byte && !take_pad) |=> $stable(rem)); // R3

endmodule

// File: rtl/crc32_byte_top.sv
module crc32_byte_top #(
  parameter int          DATA_W = 8,
  parameter int          CRC_W  = 32,
  parameter logic [31:0] POLY   = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              in_last,
  output logic [CRC_W-1:0]  crc_out,
  output logic              done
);
  localparam int PAD_BYTES = CRC_W / DATA_W;

  logic              accept, pad_active;
  logic [DATA_W-1:0] lut_idx;
  logic [CRC_W-1:0]  lut_value;

  crc32_pad_seq #(.PAD_BYTES(PAD_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_last(in_last), .accept(accept), .pad_active(pad_active), .done(done)
  );

  crc32_byte_lut #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_lut (
    .idx(lut_idx), .value(lut_value)
  );

  crc32_rem_reg #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_rem (
    .clk(clk), .rst_n(rst_n), .clear(start), .take_byte(accept),
    .take_pad(pad_active), .in_byte(in_byte), .lut_value(lut_value),
    .lut_idx(lut_idx), .rem(crc_out)
  );

  AST_START_BEATS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_valid) |=> (crc_out == '0)); // R8

endmodule

// File: tb/crc32_byte_top_tb_top.sv
module crc32_byte_top_tb_top;
  localparam logic [31:0] GEN = 32'h04C11DB7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, in_valid, in_last;
  logic [7:0]  in_byte;
  logic [31:0] crc_out;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q [$];
  logic        prev_done = 1'b0;
  logic [7:0]  msg [64];

  always #4 clk = ~clk; // 125 MHz

  crc32_byte_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_byte(in_byte),
    .in_valid(in_valid), .in_last(in_last), .crc_out(crc_out), .done(done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Bit-serial augmented model: message bits then 32 zero bits.
  function automatic logic [31:0] ref_crc(input int len);
    logic [31:0] r = '0;
    logic        top;
    for (int i = 0; i < len + 4; i++) begin
      for (int b = 7; b >= 0; b--) begin
        top = r[31];
        r = {r[30:0], (i < len) ? msg[i][b] : 1'b0};
        if (top) r = r ^ GEN;
      end
    end
    return r;
  endfunction

  // Monitor: pop and compare on every done pulse.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (prev_done && done)
        check(1'b0, "R6 done wider than one cycle", 32'(done), 32'd0);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected done", crc_out, 32'd0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(crc_out === e, "R7 R4 final remainder", crc_out, e);
        end
      end
    end
    prev_done = done;
  end

  task automatic drive_idle();
    start = 0; in_valid = 0; in_last = 0; in_byte = 8'h00;
  endtask

  task automatic send_msg(input int len, input bit junk_pad, input bit start_data);
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
    exp_q.push_back(ref_crc(len));
    @(negedge clk);
    start = 1; in_valid = start_data; in_byte = 8'hAA; in_last = 0;
    @(negedge clk);
    start = 0;
    if (start_data) check(crc_out === 32'd0, "R8 start drops byte", crc_out, 32'd0);
    for (int i = 0; i < len; i++) begin
      while ($urandom_range(3) == 0) begin
        in_valid = 0; @(negedge clk);
      end
      in_valid = 1; in_byte = msg[i]; in_last = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    if (junk_pad) begin
      for (int k = 0; k < 4; k++) begin
        in_valid = 1; in_byte = 8'($urandom); in_last = 1'($urandom);
        @(negedge clk);
      end
      in_valid = 0; in_last = 0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] held;
    drive_idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(crc_out === 32'd0 && done === 1'b0, "R1 reset state", crc_out, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check(crc_out === 32'd0 && done === 1'b0, "R1 after release", crc_out, 32'd0);

    // R7 / R6: single byte 0x01, done timing
    exp_q.push_back(32'h04C11DB7);
    start = 1; @(negedge clk); start = 0;
    in_valid = 1; in_byte = 8'h01; in_last = 1;
    @(negedge clk);
    drive_idle();
    for (int k = 1; k <= 4; k++) begin
      check(done === 1'b0, "R6 no early done", 32'(done), 32'd0);
      @(negedge clk);
    end
    check(done === 1'b1, "R6 done in fifth cycle", 32'(done), 32'd1);
    @(negedge clk);

    // R4 / R3: byte entry and hold across gaps
    start = 1; @(negedge clk); start = 0;
    in_valid = 1; in_byte = 8'h5C; @(negedge clk);
    check(crc_out === 32'h0000005C, "R4 first byte", crc_out, 32'h0000005C);
    in_byte = 8'h12; @(negedge clk);
    check(crc_out === 32'h00005C12, "R4 second byte", crc_out, 32'h00005C12);
    held = crc_out;
    in_valid = 0; in_byte = 8'hFF;
    repeat (3) @(negedge clk);
    check(crc_out === held, "R3 valid-low hold", crc_out, held);

    // R2: start mid-message
    start = 1; @(negedge clk); start = 0;
    check(crc_out === 32'd0, "R2 start clears", crc_out, 32'd0);

    // R2: start aborts padding, no done follows (monitor flags any done)
    in_valid = 1; in_byte = 8'h80; in_last = 1; @(negedge clk);
    drive_idle(); @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    check(crc_out === 32'd0, "R2 abort padding clears", crc_out, 32'd0);
    repeat (8) @(negedge clk);
    check(crc_out === 32'd0, "R2 abort holds zero", crc_out, 32'd0);

    // R5: junk with valid high during padding, R8: start with data
    send_msg(3, 1'b1, 1'b0);
    send_msg(9, 1'b1, 1'b1);
    send_msg(64, 1'b0, 1'b1);

    // R7: random lengths 1..64 against bit-serial model
    for (int m = 0; m < 40; m++)
      send_msg($urandom_range(64, 1), 1'($urandom), 1'($urandom));

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule